// File: doc/BRIEF.md
# Soft Interrupt and Compare Timer

This block is a privileged timer-interrupt unit. It keeps a 63-bit tick counter that advances on every clock, two 64-bit compare registers and a 17-bit soft-interrupt pending register. One compare register is for the supervisor and one is for the hypervisor. Software reaches everything through a small register bus with an address, write data, a write enable and combinational read data. The pending register can be written in three ways: a direct write replaces it, a set alias ORs bits in, and a clear alias removes bits.

The top bit of each compare register disables it. An enabled compare fires in the clock in which the counter holds the compare value. A supervisor match posts the timer bit (bit 16) of the pending register. A hypervisor match posts no bit. Any event that can change which interrupt should be taken produces a one-clock recheck pulse. These events are a pending-register write, either compare match, a drop of the interrupt level, and the interrupt enable turning on. A level register and an enable bit live in the same register space. An interrupt request output shows whether a pending bit outranks the current level. Trap delivery and vectoring belong to the consumer of these outputs.

Top module: `soft_intr_timer`

## Requirements
- R1: A write to address 0 replaces the 17-bit pending register with write data bits 16:0, and higher data bits are dropped. Reads of addresses 0, 1 and 2 return the pending register in bits 16:0, with zeros above. After reset the register is 0.
- R2: A write to address 1 ORs write data bits 16:0 into the pending register.
- R3: A write to address 2 clears every pending bit whose write data bit is 1 and leaves the others unchanged.
- R4: Every write to address 0, 1 or 2 makes `recheck_pulse` high for exactly the one clock that follows the write edge. The pulse is registered.
- R5: The counter (address 5, bits 62:0, read with bit 63 as 0) is 0 after reset and increases by one each clock. A write loads bits 62:0 and the counter holds that value in the next clock. After 2^63-1 the counter wraps to 0.
- R6: The supervisor compare is at address 3 and the hypervisor compare at address 4. In each, bit 63 is the disable flag and bits 62:0 are the value; both reset to disabled with value 0. When the supervisor compare is enabled and the counter equals its value, bit 16 of the pending register is set at the next edge and `recheck_pulse` is high in the clock after that edge.
- R7: An enabled hypervisor match raises `recheck_pulse` in the same way and sets no pending bit.
- R8: A compare whose bit 63 is 1 never fires.
- R9: A write to the level register (address 6, bits 3:0, reset 0) with a value below the current level raises `recheck_pulse`. A write of an equal or higher value does not.
- R10: A write to address 7 that turns enable bit 0 from 0 to 1 raises `recheck_pulse`. Writing 1 while the bit is already 1, or writing 0, does not. Address 7 reads back the bit in bit 0, and the bit resets to 0.
- R11: `irq_req` is high while some pending bit n, for n from 1 to 15, is set with n greater than the level, or while bit 16 is set and 14 is greater than the level. Bit 0 never requests.
- R12: A compare value written at or below the current counter does not fire until the counter wraps around and reaches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 64 | Write data |
| reg_we | input | 1 | Write enable, one write per clock |
| reg_rdata | output | 64 | Read data for `reg_addr` (combinational) |
| irq_req | output | 1 | A pending bit outranks the current level |
| recheck_pulse | output | 1 | One-clock pulse: interrupt state may have changed |

## Verification
The bench samples the clock just before and the clock just after a compare match. A design that compares against the next counter value, or that adds a register stage, posts the timer bit one clock off. It loads the counter near its top value and lets it wrap into a compare value of 1. A counter that saturates, or a compare that uses a magnitude test, either never fires or fires early. It writes equal and higher levels, and repeats enable writes, all of which must stay silent. An edge detector built on the wrong side would pulse on these. It also checks that the pulse drops after one clock, and that a disabled or past compare does not set bit 16.

// File: rtl/sit_pkg.sv
package sit_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_PEND     = 3'd0;
    localparam logic [ADDR_W-1:0] A_PEND_SET = 3'd1;
    localparam logic [ADDR_W-1:0] A_PEND_CLR = 3'd2;
    localparam logic [ADDR_W-1:0] A_SUP_CMP  = 3'd3;
    localparam logic [ADDR_W-1:0] A_HYP_CMP  = 3'd4;
    localparam logic [ADDR_W-1:0] A_COUNT    = 3'd5;
    localparam logic [ADDR_W-1:0] A_LEVEL    = 3'd6;
    localparam logic [ADDR_W-1:0] A_CTRL     = 3'd7;

    localparam int NUM_CMP = 2;
    localparam int CMP_SUP = 0;
    localparam int CMP_HYP = 1;
endpackage

// File: rtl/sit_tick_counter.sv
module sit_tick_counter #(
    parameter int CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

    // R5: free-running step with modulo wrap
    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load)) |-> (count == $past(count) + 1'b1));

    // R5: a load is seen in the next clock
    assert_count_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)));
endmodule

// File: rtl/sit_compare.sv
module sit_compare #(
    parameter int VAL_W = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [VAL_W:0]   wdata,
    input  logic [VAL_W-1:0] count,
    output logic [VAL_W:0]   cmp_reg,
    output logic             fire
);
    typedef struct packed {
        logic [VAL_W:0] cmp;
    } cmp_state_t;

    cmp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.cmp = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cmp <= {1'b1, {VAL_W{1'b0}}};
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_reg = st_q.cmp;
    assign fire    = !st_q.cmp[VAL_W] && (st_q.cmp[VAL_W-1:0] == count);
endmodule

// File: rtl/sit_softint.sv
module sit_softint #(
    parameter int SI_W      = 17,
    parameter int TIMER_BIT = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_direct,
    input  logic            wr_set,
    input  logic            wr_clr,
    input  logic [SI_W-1:0] wdata,
    input  logic            post_timer,
    output logic [SI_W-1:0] pend
);
    typedef struct packed {
        logic [SI_W-1:0] bits;
    } si_state_t;

    si_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_direct) begin
            st_d.bits = wdata;
        end
        if (wr_set) begin
            st_d.bits = st_d.bits | wdata;
        end
        if (wr_clr) begin
            st_d.bits = st_d.bits & ~wdata;
        end
        if (post_timer) begin
            st_d.bits[TIMER_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.bits;

    // R2: every bit written through the set alias is 1 afterwards
    assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((pend & $past(wdata)) == $past(wdata)));

    // R3: every bit written through the clear alias is 0 afterwards
    assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !post_timer) |=> ((pend & $past(wdata)) == '0));
endmodule

// File: rtl/sit_irq_prio.sv
module sit_irq_prio #(
    parameter int SI_W      = 17,
    parameter int LVL_W     = 4,
    parameter int TIMER_BIT = 16,
    parameter int TIMER_LVL = 14
) (
    input  logic [SI_W-1:1]  pend_hi,
    input  logic [LVL_W-1:0] level,
    output logic             irq
);
    always_comb begin
        irq = 1'b0;
        for (int n = 1; n < SI_W; n++) begin
            int lv;
            lv = (n == TIMER_BIT) ? TIMER_LVL : n;
            if (pend_hi[n] && (lv > int'(level))) begin
                irq = 1'b1;
            end
        end
    end
endmodule

// File: rtl/soft_intr_timer.sv
module soft_intr_timer #(
    parameter int CNT_W     = 63,
    parameter int SI_W      = 17,
    parameter int LVL_W     = 4,
    parameter int TIMER_BIT = 16,
    parameter int TIMER_LVL = 14
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [sit_pkg::ADDR_W-1:0] reg_addr,
    input  logic [CNT_W:0]            reg_wdata,
    input  logic                      reg_we,
    output logic [CNT_W:0]            reg_rdata,
    output logic                      irq_req,
    output logic                      recheck_pulse
);
    import sit_pkg::*;

    localparam int DATA_W = CNT_W + 1;

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic             ie;
        logic             recheck;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [CNT_W-1:0]  count;
    logic [SI_W-1:0]   pend;
    logic [DATA_W-1:0] cmp_val  [NUM_CMP];
    logic [NUM_CMP-1:0] cmp_fire;

    logic wr_pend, wr_set, wr_clr, wr_cnt, wr_lvl, wr_ctrl, pend_any_wr;

    assign wr_pend     = reg_we && (reg_addr == A_PEND);
    assign wr_set      = reg_we && (reg_addr == A_PEND_SET);
    assign wr_clr      = reg_we && (reg_addr == A_PEND_CLR);
    assign wr_cnt      = reg_we && (reg_addr == A_COUNT);
    assign wr_lvl      = reg_we && (reg_addr == A_LEVEL);
    assign wr_ctrl     = reg_we && (reg_addr == A_CTRL);
    assign pend_any_wr = wr_pend || wr_set || wr_clr;

    sit_tick_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_cnt),
        .load_val (reg_wdata[CNT_W-1:0]),
        .count    (count)
    );

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        localparam logic [ADDR_W-1:0] MY_ADDR = (g == CMP_SUP) ? A_SUP_CMP : A_HYP_CMP;
        logic cmp_wr;
        assign cmp_wr = reg_we && (reg_addr == MY_ADDR);

        sit_compare #(.VAL_W(CNT_W)) u_cmp (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (cmp_wr),
            .wdata   (reg_wdata),
            .count   (count),
            .cmp_reg (cmp_val[g]),
            .fire    (cmp_fire[g])
        );
    end

    sit_softint #(.SI_W(SI_W), .TIMER_BIT(TIMER_BIT)) u_softint (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_direct  (wr_pend),
        .wr_set     (wr_set),
        .wr_clr     (wr_clr),
        .wdata      (reg_wdata[SI_W-1:0]),
        .post_timer (cmp_fire[CMP_SUP]),
        .pend       (pend)
    );

    sit_irq_prio #(
        .SI_W(SI_W), .LVL_W(LVL_W), .TIMER_BIT(TIMER_BIT), .TIMER_LVL(TIMER_LVL)
    ) u_prio (
        .pend_hi (pend[SI_W-1:1]),
        .level   (st_q.level),
        .irq     (irq_req)
    );

    always_comb begin
        logic lvl_drop, ie_rise;
        st_d     = st_q;
        lvl_drop = wr_lvl && (reg_wdata[LVL_W-1:0] < st_q.level);
        ie_rise  = wr_ctrl && reg_wdata[0] && !st_q.ie;
        if (wr_lvl) begin
            st_d.level = reg_wdata[LVL_W-1:0];
        end
        if (wr_ctrl) begin
            st_d.ie = reg_wdata[0];
        end
        st_d.recheck = pend_any_wr || (|cmp_fire) || lvl_drop || ie_rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign recheck_pulse = st_q.recheck;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_PEND, A_PEND_SET, A_PEND_CLR: reg_rdata[SI_W-1:0] = pend;
            A_SUP_CMP: reg_rdata = cmp_val[CMP_SUP];
            A_HYP_CMP: reg_rdata = cmp_val[CMP_HYP];
            A_COUNT:   reg_rdata[CNT_W-1:0] = count;
            A_LEVEL:   reg_rdata[LVL_W-1:0] = st_q.level;
            A_CTRL:    reg_rdata[0] = st_q.ie;
            default:   reg_rdata = '0;
        endcase
    end

    // R4: any pending-register write is followed by a recheck pulse
    assert_pend_wr_recheck_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_addr == A_PEND || reg_addr == A_PEND_SET || reg_addr == A_PEND_CLR))
        |=> recheck_pulse);

    // R6: a supervisor match posts the timer bit and a recheck pulse
    assert_sup_post_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_fire[CMP_SUP] |=> (pend[TIMER_BIT] && recheck_pulse));

    // R7: a hypervisor match raises a recheck pulse
    assert_hyp_recheck_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_fire[CMP_HYP] |=> recheck_pulse);

    // R8: with the supervisor compare disabled and no bus write, bit 16 does not rise
    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(reg_we) && $past(cmp_val[CMP_SUP][CNT_W]))
        |-> !$rose(pend[TIMER_BIT]));

    // R9: a lower level write is followed by a recheck pulse
    assert_level_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lvl && (reg_wdata[LVL_W-1:0] < reg_rdata_level())) |=> recheck_pulse);

    // R11: nothing pending means no request
    assert_no_req_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[SI_W-1:1] == '0) |-> !irq_req);

    function automatic logic [LVL_W-1:0] reg_rdata_level();
        return st_q.level;
    endfunction
endmodule

// File: tb/soft_intr_timer_tb.sv
module soft_intr_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic [63:0] wdata = '0;
    logic        we = 1'b0;
    logic [63:0] rdata;
    logic        irq;
    logic        recheck;

    always #10 clk = ~clk;

    soft_intr_timer dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_addr      (addr),
        .reg_wdata     (wdata),
        .reg_we        (we),
        .reg_rdata     (rdata),
        .irq_req       (irq),
        .recheck_pulse (recheck)
    );

    localparam int K_RD = 0, K_IRQ = 1, K_RCK = 2;

    typedef struct {
        int          kind;
        logic [2:0]  a;
        logic [63:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // monitor: pops one expected item per falling edge and compares
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            logic [63:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                K_RD:    act = rdata;
                K_IRQ:   act = {63'b0, irq};
                default: act = {63'b0, recheck};
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_errors++;
                $display("FAIL %s kind=%0d addr=%0d actual=%h expected=%h",
                         it.tag, it.kind, it.a, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        @(posedge clk); #2;
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk); #2;
        we = 1'b0;
    endtask

    task automatic expect_item(input int kind, input logic [2:0] a,
                               input logic [63:0] e, input string tag);
        item_t it;
        if (kind == K_RD) addr = a;
        it.kind = kind; it.a = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic rd(input logic [2:0] a, input logic [63:0] e, input string tag);
        expect_item(K_RD, a, e, tag);
    endtask

    task automatic sig(input int kind, input logic v, input string tag);
        expect_item(kind, 3'd0, {63'b0, v}, tag);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // reset state
        rd(3'd0, 64'h0, "R1 reset pending");
        sig(K_IRQ, 1'b0, "R11 reset irq");
        sig(K_RCK, 1'b0, "R4 reset recheck");
        rd(3'd3, 64'h8000_0000_0000_0000, "R8 reset compare disabled");
        rd(3'd7, 64'h0, "R10 reset enable");

        // direct, set and clear
        wr(3'd0, 64'h2_00F0);
        sig(K_RCK, 1'b1, "R4 direct write pulse");
        sig(K_RCK, 1'b0, "R4 pulse one clock");
        rd(3'd0, 64'h00F0, "R1 direct write value");
        wr(3'd1, 64'h3);
        sig(K_RCK, 1'b1, "R4 set write pulse");
        rd(3'd1, 64'h00F3, "R2 set alias OR");
        wr(3'd2, 64'h31);
        sig(K_RCK, 1'b1, "R4 clear write pulse");
        rd(3'd0, 64'h00C2, "R3 clear alias");

        // level and request
        sig(K_IRQ, 1'b1, "R11 bit7 over level0");
        wr(3'd6, 64'd7);
        sig(K_RCK, 1'b0, "R9 higher level silent");
        sig(K_IRQ, 1'b0, "R11 level7 masks bit7");
        wr(3'd6, 64'd6);
        sig(K_RCK, 1'b1, "R9 lower level pulse");
        sig(K_IRQ, 1'b1, "R11 bit7 over level6");
        wr(3'd6, 64'd6);
        sig(K_RCK, 1'b0, "R9 equal level silent");
        wr(3'd0, 64'h1_0001);
        sig(K_IRQ, 1'b1, "R11 timer bit at level6");
        wr(3'd6, 64'd14);
        sig(K_IRQ, 1'b0, "R11 timer bit masked at 14");
        wr(3'd6, 64'd13);
        sig(K_IRQ, 1'b1, "R11 timer bit over 13");
        wr(3'd0, 64'h1);
        sig(K_IRQ, 1'b0, "R11 bit0 never requests");

        // enable edge
        wr(3'd7, 64'h1);
        sig(K_RCK, 1'b1, "R10 enable rise pulse");
        wr(3'd7, 64'h1);
        sig(K_RCK, 1'b0, "R10 enable repeat silent");
        wr(3'd7, 64'h0);
        sig(K_RCK, 1'b0, "R10 enable off silent");
        rd(3'd7, 64'h0, "R10 enable readback");

        // counter
        wr(3'd5, 64'd100);
        rd(3'd5, 64'd100, "R5 counter load");
        rd(3'd5, 64'd101, "R5 counter step");

        // supervisor compare, exact cycle
        wr(3'd0, 64'h0);
        wr(3'd3, 64'd1000);
        wr(3'd5, 64'd997);
        repeat (3) @(posedge clk);
        rd(3'd0, 64'h0, "R6 no post before match");
        sig(K_RCK, 1'b1, "R6 match pulse");
        rd(3'd0, 64'h1_0000, "R6 timer bit posted");

        // hypervisor compare
        wr(3'd0, 64'h0);
        wr(3'd4, 64'd3000);
        wr(3'd5, 64'd2997);
        repeat (3) @(posedge clk);
        sig(K_RCK, 1'b0, "R7 no pulse before match");
        sig(K_RCK, 1'b1, "R7 hyp match pulse");
        rd(3'd0, 64'h0, "R7 no pending bit");

        // disabled compares
        wr(3'd0, 64'h0);
        wr(3'd3, 64'h8000_0000_0000_1388);
        wr(3'd4, 64'h8000_0000_0000_1388);
        wr(3'd5, 64'd4995);
        repeat (12) @(posedge clk);
        rd(3'd0, 64'h0, "R8 disabled compare quiet");
        rd(3'd3, 64'h8000_0000_0000_1388, "R6 compare readback");

        // past value, then wrap
        wr(3'd3, 64'd200);
        repeat (30) @(posedge clk);
        rd(3'd0, 64'h0, "R12 past compare quiet");
        wr(3'd3, 64'd1);
        wr(3'd5, 64'h7FFF_FFFF_FFFF_FFFD);
        repeat (3) @(posedge clk);
        rd(3'd5, 64'h0, "R5 counter wraps to 0");
        rd(3'd0, 64'h0, "R12 not yet at value");
        rd(3'd0, 64'h1_0000, "R12 fires after wrap");

        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule